// File: doc/BRIEF.md
# Successive-Cancellation Partial-Sum Feedback Unit

This unit sits beside the LLR datapath of a successive-cancellation polar decoder and supplies the partial sums that every g-node evaluation needs. Decoded bits arrive two at a time, an even-indexed bit and the odd-indexed bit after it. For each tree level, the unit keeps the re-encoded image of the most recently finished left-half block of decoded bits. When the decoder moves into the matching right half, the g-nodes of that level read this image.

Storage is a set of flip-flops, one register group per level. Each group has a load/hold multiplexer in front of it. A pair sequencer counts the pairs of the codeword. It raises a level's load strobe only on the pair that completes a left-half block at that level. On every other pair, and in idle cycles, the register keeps its value. The new content of a level is built from the level below: the stored left image and the freshly completed right image. The lower half of the new content is their XOR and the upper half is the right image. This lets the encoding grow recursively with no shift chain.

Top module: `psum_feedback`

## Requirements
- R1: While `rst_n` is low at a clock edge, `psum_o` and `pair_idx_o` become all zeros on that edge.
- R2: A clock edge with `frame_start` high clears `psum_o` and `pair_idx_o` to zero. This takes priority over a pair offered in the same cycle, and that pair is discarded.
- R3: Each edge with `pair_valid` high and `frame_start` low accepts the pair as pair number `pair_idx_o` (bits 2p and 2p+1 of the codeword). `pair_idx_o` then advances by one, and wraps from N/2-1 to 0.
- R4: For level s (1 <= s < log2 N, block size B = 2^s), the pair p with 2p+2 an odd multiple of B completes the left block starting at bit b = 2p+2-B. After that edge, bit j of the level-s field equals the XOR of codeword bits b+k over all k < B with (k AND j) == j.
- R5: A level's field does not change on accepted pairs that do not complete a left block of that level. In particular it holds when bit s-1 of the pair index is 1 (right half of the level).
- R6: In a cycle with `pair_valid` and `frame_start` both low, `psum_o` and `pair_idx_o` keep their values.
- R7: The level-s field occupies `psum_o` bits [2^(s+1)-3 : 2^s-2], and local bit j sits at `psum_o` bit 2^s-2+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | Synchronous clear at the start of a codeword |
| pair_valid | input | 1 | A decoded bit pair is offered this cycle |
| bit_even | input | 1 | Decoded bit with index 2p |
| bit_odd | input | 1 | Decoded bit with index 2p+1 |
| psum_o | output | N-2 | Stored partial-sum images of levels 1 to log2 N - 1, packed by level |
| pair_idx_o | output | log2 N - 1 | Index of the next pair expected |

## Verification
The encoding is linear, so the bench drives every codeword with a single set bit. Each set bit lights exactly the field bits that the generator rows put there. A wrong XOR subset or a swapped half shows up as a stray or missing bit at a known position. Random codewords test loads on every pair position. Idle gaps between pairs catch a design that loads or counts on cycles without a pair. A run past the wrap with no `frame_start` shows whether the fields of the previous codeword are kept until overwritten. A `frame_start` that coincides with a pair catches a design that lets the pair in ahead of the clear.

// File: rtl/psum_pkg.sv
package psum_pkg;

    // Offset of a level inside a flat vector that packs levels 0,1,2,...
    // with level s being 2^s bits wide.
    function automatic int level_base(input int s);
        return (1 << s) - 1;
    endfunction

endpackage

// File: rtl/psum_seq.sv
module psum_seq #(
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          pair_valid,
    output logic [IW-1:0] idx_o,
    output logic [IW:1]   load_o
);

    typedef struct packed {
        logic [IW-1:0] idx;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!rst_n || clr) begin
            seq_d.idx = '0;
        end else if (pair_valid) begin
            seq_d.idx = seq_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    // Level s loads on the pair that closes a left block of 2^s bits:
    // the low s-1 index bits are all ones and index bit s-1 is zero.
    for (genvar s = 1; s <= IW; s++) begin : g_load
        localparam logic [IW-1:0] LOW_MASK = IW'((1 << (s - 1)) - 1);
        assign load_o[s] = pair_valid && !clr && rst_n
                           && ((seq_q.idx & LOW_MASK) == LOW_MASK)
                           && !seq_q.idx[s-1];
    end

    assign idx_o = seq_q.idx;

endmodule

// File: rtl/psum_stage.sv
module psum_stage #(
    parameter int HALF = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [HALF-1:0]   low_store,
    input  logic [HALF-1:0]   low_comp,
    output logic [2*HALF-1:0] store_o
);

    typedef struct packed {
        logic [2*HALF-1:0] img;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n || clr) begin
            st_d.img = '0;
        end else if (load) begin
            st_d.img = {low_comp, low_store ^ low_comp};
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign store_o = st_q.img;

endmodule

// File: rtl/psum_feedback.sv
module psum_feedback #(
    parameter int N = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    frame_start,
    input  logic                    pair_valid,
    input  logic                    bit_even,
    input  logic                    bit_odd,
    output logic [N-3:0]            psum_o,
    output logic [$clog2(N)-2:0]    pair_idx_o
);

    import psum_pkg::*;

    localparam int LOGN = $clog2(N);
    localparam int IW   = LOGN - 1;

    // Stored left images, level 0 is the even bit of the current pair.
    logic [N-2:0]   store_flat;
    // Just-completed right images, levels 0 .. LOGN-2.
    logic [N/2-2:0] comp_flat;
    logic [IW:1]    stage_load;

    assign store_flat[0] = bit_even;
    assign comp_flat[0]  = bit_odd;

    psum_seq #(.IW(IW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (frame_start),
        .pair_valid (pair_valid),
        .idx_o      (pair_idx_o),
        .load_o     (stage_load)
    );

    for (genvar s = 1; s < LOGN; s++) begin : g_lvl
        localparam int H   = 1 << (s - 1);
        localparam int LB  = level_base(s - 1);
        localparam int OB  = level_base(s);

        psum_stage #(.HALF(H)) u_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (frame_start),
            .load      (stage_load[s]),
            .low_store (store_flat[LB +: H]),
            .low_comp  (comp_flat[LB +: H]),
            .store_o   (store_flat[OB +: 2*H])
        );

        if (s < LOGN - 1) begin : g_comp
            assign comp_flat[OB +: 2*H] =
                {comp_flat[LB +: H], store_flat[LB +: H] ^ comp_flat[LB +: H]};
        end
    end

    assign psum_o = store_flat[N-2:1];

endmodule

// File: rtl/psum_feedback_chk.sv
module psum_feedback_chk #(
    parameter int N = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_start,
    input logic                 pair_valid,
    input logic                 bit_even,
    input logic                 bit_odd,
    input logic [N-3:0]         psum_o,
    input logic [$clog2(N)-2:0] pair_idx_o
);

    localparam int LOGN = $clog2(N);
    localparam int IW   = LOGN - 1;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (psum_o == '0 && pair_idx_o == '0));

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (psum_o == '0 && pair_idx_o == '0));

    // R3
    idx_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_valid && !frame_start)
        |=> pair_idx_o == IW'($past(pair_idx_o) + 1'b1));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pair_valid && !frame_start)
        |=> ($stable(psum_o) && $stable(pair_idx_o)));

    for (genvar s = 1; s < LOGN; s++) begin : g_hold
        localparam int OFF = (1 << s) - 2;
        localparam int W   = 1 << s;
        // R5
        right_half_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (pair_valid && !frame_start && pair_idx_o[s-1])
            |=> $stable(psum_o[OFF +: W]));
    end

    logic unused_bits;
    assign unused_bits = bit_even ^ bit_odd;

endmodule

bind psum_feedback psum_feedback_chk #(.N(N)) u_chk (.*);

// File: tb/sim_psum_feedback.sv
module sim_psum_feedback;

    localparam int N    = 16;
    localparam int LOGN = 4;
    localparam int IW   = LOGN - 1;
    localparam int PW   = N - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          pair_valid = 1'b0;
    logic          bit_even = 1'b0;
    logic          bit_odd = 1'b0;
    logic [PW-1:0] psum_o;
    logic [IW-1:0] pair_idx_o;

    int checks = 0;
    int errors = 0;

    // Bench model
    logic [N-1:0] cw;
    logic [N-1:0] exp_f [1:LOGN-1];
    int           exp_idx;

    always #2 clk = ~clk;

    psum_feedback #(.N(N)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .pair_valid  (pair_valid),
        .bit_even    (bit_even),
        .bit_odd     (bit_odd),
        .psum_o      (psum_o),
        .pair_idx_o  (pair_idx_o)
    );

    function automatic logic [PW-1:0] exp_vec();
        logic [PW-1:0] v = '0;
        for (int s = 1; s < LOGN; s++) begin
            for (int j = 0; j < (1 << s); j++) begin
                v[(1 << s) - 2 + j] = exp_f[s][j];   // R7 layout
            end
        end
        return v;
    endfunction

    function automatic logic enc_bit(input int start, input int blk, input int j);
        logic x = 1'b0;
        for (int k = 0; k < blk; k++) begin
            if ((k & j) == j) x = x ^ cw[start + k];
        end
        return x;
    endfunction

    task automatic model_clear();
        for (int s = 1; s < LOGN; s++) exp_f[s] = '0;
        exp_idx = 0;
    endtask

    task automatic check_all(input string tag);
        logic [PW-1:0] ev;
        ev = exp_vec();
        checks++;
        if (psum_o !== ev) begin
            errors++;
            $display("FAIL %s psum actual=%h expected=%h", tag, psum_o, ev);
        end
        checks++;
        if (pair_idx_o !== IW'(exp_idx)) begin
            errors++;
            $display("FAIL R3 (%s) pair_idx actual=%0d expected=%0d", tag, pair_idx_o, exp_idx);
        end
    endtask

    task automatic send_pair(input logic e, input logic o);
        int p;
        p = exp_idx;
        pair_valid = 1'b1;
        bit_even   = e;
        bit_odd    = o;
        @(posedge clk);
        #1;
        pair_valid = 1'b0;
        cw[2*p]     = e;
        cw[2*p + 1] = o;
        for (int s = 1; s < LOGN; s++) begin
            int blk;
            blk = 1 << s;
            if (((2*p + 2) % blk) == 0 && (((2*p + 2) / blk) % 2) == 1) begin
                for (int j = 0; j < blk; j++)
                    exp_f[s][j] = enc_bit(2*p + 2 - blk, blk, j);
            end
        end
        exp_idx = (exp_idx + 1) % (N / 2);
        check_all("R4/R5/R7");
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
        check_all("R6");
    endtask

    task automatic start_frame(input logic with_pair);
        frame_start = 1'b1;
        pair_valid  = with_pair;
        bit_even    = 1'b1;
        bit_odd     = 1'b1;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        pair_valid  = 1'b0;
        model_clear();
        check_all("R2");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cw = '0;
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        check_all("R1");
        rst_n = 1'b1;

        // Random codeword, back-to-back pairs
        for (int p = 0; p < N/2; p++) send_pair(1'($urandom), 1'($urandom));
        // Wrap into a second codeword without a clear, with idle gaps
        for (int p = 0; p < N/2; p++) begin
            send_pair(1'($urandom), 1'($urandom));
            idle(1 + (p % 3));
        end

        // Unit codewords: one set bit per codeword
        for (int b = 0; b < N; b++) begin
            start_frame(1'b0);
            for (int p = 0; p < N/2; p++)
                send_pair(1'(2*p == b), 1'(2*p + 1 == b));
        end

        // All-ones codeword
        start_frame(1'b0);
        for (int p = 0; p < N/2; p++) send_pair(1'b1, 1'b1);

        // Clear in the middle with a colliding pair
        start_frame(1'b0);
        for (int p = 0; p < 3; p++) send_pair(1'b1, 1'b0);
        start_frame(1'b1);
        for (int p = 0; p < N/2; p++) send_pair(1'($urandom), 1'($urandom));

        // Reset in mid-codeword
        send_pair(1'b1, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_clear();
        check_all("R1");
        rst_n = 1'b1;
        for (int p = 0; p < N/2; p++) send_pair(1'($urandom), 1'($urandom));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule